// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block narrows a 32-bit binary floating-point operand to a 16-bit half-precision result, with a single register stage. The result and its exception flags appear one clock after the operand is presented. A format select picks one of two output formats. The first is standard half precision. The second is a half format with no NaN or infinity codes, in which the all-ones exponent holds ordinary finite values.

Rounding follows a 3-bit mode code. Results below the normal range become subnormals and then signed zero. Results too large for the chosen format take the overflow path of that format. NaN operands are quieted, or replaced by a fixed default NaN when that option is enabled. Subnormal operands can be flushed to zero before conversion.

The flags are returned with every result and are not accumulated. The block is meant to sit at the end of a conversion pipe, and software or a later stage collects the flags.

Top module: `sp_to_hp_narrow`

## Requirements
- R1: The result and flags are registered with a latency of one clock. While `rst_n` is low both read zero. The flag bits are: bit 3 invalid, bit 2 overflow, bit 1 underflow, bit 0 inexact.
- R2: Finite operands are rounded to 10 fraction bits using the rounding code: 0 nearest-even (an exact tie goes to the even result), 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest with ties away from zero. Codes 5 to 7 act as code 0. A carry out of rounding increments the exponent. Any discarded nonzero bit sets inexact.
- R3: In standard mode (`alt_fmt`=0), a result whose magnitude after rounding exceeds 0x7BFF sets overflow and inexact. It returns the signed infinity 0x7C00 under the nearest codes and in the direction of rounding. In the other directed cases it returns the signed largest finite value 0x7BFF.
- R4: In alternative mode (`alt_fmt`=1), exponent 31 encodes finite values, so the largest magnitude is 0x7FFF. A larger result returns that signed maximum and sets invalid only, never overflow.
- R5: In standard mode a NaN operand returns sign, exponent 31, fraction bit 9 set, and fraction bits 8..0 taken from operand bits 21..13. A signaling NaN (operand bit 22 clear) sets invalid. A quiet NaN sets no flag.
- R6: With `dnan_en` set in standard mode, every NaN operand returns 0x7E00. Invalid is still set for a signaling NaN.
- R7: In alternative mode, a NaN operand returns a zero carrying the NaN's sign, and an infinite operand returns the signed value 0x7FFF. Both set invalid.
- R8: In standard mode an infinite operand returns the signed infinity with no flags.
- R9: Results below 2^-14 are encoded as subnormals. Results that round below the smallest subnormal become signed zero. A subnormal that rounds up to 2^-14 is encoded as 0x0400 with the sign.
- R10: Underflow is raised only when the result is both tiny and inexact. With `tiny_before`=1, any value below 2^-14 before rounding is tiny. With `tiny_before`=0, a value is tiny only if its rounded magnitude is still below 0x0400.
- R11: With `flush_in_dn` set, a subnormal operand becomes a signed zero with no flags. With it clear, the operand is converted and rounded like any other value.
- R12: A zero operand of either sign returns a zero of the same sign with no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_bits | input | 32 | Operand in 32-bit binary format |
| alt_fmt | input | 1 | 0 standard half, 1 half format without NaN/infinity |
| rnd_mode | input | 3 | Rounding code |
| tiny_before | input | 1 | 1 detects tininess before rounding, 0 after |
| dnan_en | input | 1 | Replace NaN results by the default NaN |
| flush_in_dn | input | 1 | Flush subnormal operands to zero |
| dst_bits | output | 16 | Half-precision result |
| dst_flags | output | 4 | Invalid, overflow, underflow, inexact |

## Verification
The datapath holds no state beyond the output register, so an internal fault shows at the ports on the clock after the operand that triggers it. A wrong shift amount or guard/sticky extraction shows as an off-by-one-ULP result or a missing inexact bit, and typically only near ties or near the subnormal boundary. A wrong overflow limit or format select appears first at 0x7BFF/0x7C00 in one mode and 0x7FFF in the other. The directed vectors sit on those edges, and a broad sweep compares against an independently written bit-serial model.

// File: rtl/spn_pkg.sv
package spn_pkg;
  localparam int SP_W   = 32;
  localparam int SP_EW  = 8;
  localparam int SP_FW  = 23;
  localparam int HP_W   = 16;
  localparam int HP_EW  = 5;
  localparam int HP_FW  = 10;
  localparam int SP_BIAS = 127;
  localparam int HP_BIAS = 15;
  localparam int SIG_W  = SP_FW + 1;
  localparam int FLG_W  = 4;
  localparam int FLG_NV = 3;
  localparam int FLG_OF = 2;
  localparam int FLG_UF = 1;
  localparam int FLG_NX = 0;

  typedef enum logic [2:0] {
    CL_ZERO, CL_FINITE, CL_INF, CL_QNAN, CL_SNAN
  } op_class_t;

  // rounding codes: 0 even, 1 zero, 2 down, 3 up, 4 away; rest as 0
  function automatic logic rnd_incr(input logic sgn, input logic [2:0] rm,
                                    input logic lsb, input logic rb,
                                    input logic sb);
    case (rm)
      3'd1:    return 1'b0;
      3'd2:    return sgn & (rb | sb);
      3'd3:    return ~sgn & (rb | sb);
      3'd4:    return rb;
      default: return rb & (sb | lsb);
    endcase
  endfunction

  // whether an overflowing value goes to infinity (else to max finite)
  function automatic logic ovf_to_inf(input logic sgn, input logic [2:0] rm);
    case (rm)
      3'd1:    return 1'b0;
      3'd2:    return sgn;
      3'd3:    return ~sgn;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spn_classify.sv
module spn_classify
  import spn_pkg::*;
(
  input  logic [SP_W-1:0]  op,
  input  logic             flush_in_dn,
  output logic             sgn,
  output op_class_t        cls,
  output logic [SP_EW-1:0] exp_eff,
  output logic [SIG_W-1:0] sig
);
  logic [SP_EW-1:0] ef;
  logic [SP_FW-1:0] ff;
  logic             e_ones, e_zero, f_zero;

  assign sgn    = op[SP_W-1];
  assign ef     = op[SP_W-2 -: SP_EW];
  assign ff     = op[SP_FW-1:0];
  assign e_ones = &ef;
  assign e_zero = ~|ef;
  assign f_zero = ~|ff;

  always_comb begin
    exp_eff = e_zero ? SP_EW'(1) : ef;
    sig     = {~e_zero, ff};
    if (e_ones) begin
      if (f_zero)              cls = CL_INF;
      else if (ff[SP_FW-1])    cls = CL_QNAN;
      else                     cls = CL_SNAN;
    end else if (e_zero && (f_zero || flush_in_dn)) begin
      cls = CL_ZERO;
    end else begin
      cls = CL_FINITE;
    end
  end
endmodule

// File: rtl/spn_round_pack.sv
module spn_round_pack
  import spn_pkg::*;
(
  input  logic             sgn,
  input  logic [SP_EW-1:0] exp_eff,
  input  logic [SIG_W-1:0] sig,
  input  logic [2:0]       rnd_mode,
  input  logic             alt_fmt,
  input  logic             tiny_before,
  output logic [HP_W-2:0]  mag_out,
  output logic [FLG_W-1:0] flags_out,
  output logic             rnd_carry,
  output logic             ovf_hit,
  output logic             tiny_hit
);
  localparam int XW       = SP_EW + 2;
  localparam int MW       = SP_EW + HP_FW;
  localparam int NORM_SH  = SIG_W - 1 - HP_FW;
  localparam int MAX_SH   = SIG_W + 1;
  localparam int SH_W     = $clog2(MAX_SH + 1);
  localparam int REBIAS   = SP_BIAS - HP_BIAS;
  localparam logic [MW-1:0] LIM_STD  = MW'(((1 << HP_EW) - 1) << HP_FW);
  localparam logic [MW-1:0] LIM_ALT  = MW'(1 << (HP_W - 1));
  localparam logic [MW-1:0] MIN_NORM = MW'(1 << HP_FW);

  logic signed [XW-1:0] hexp, sh_full;
  logic                 is_sub;
  logic [SH_W-1:0]      sh;
  logic [SIG_W-1:0]     kept, half_mask;
  logic                 rb, st, nx;
  logic [SP_EW-1:0]     exp_field;
  logic [MW-1:0]        mag, limit;

  assign hexp    = $signed({2'b00, exp_eff}) - $signed(XW'(REBIAS));
  assign is_sub  = hexp[XW-1] || (hexp == '0);
  assign sh_full = $signed(XW'(NORM_SH + 1)) - hexp;

  always_comb begin
    if (!is_sub)                              sh = SH_W'(NORM_SH);
    else if (sh_full > $signed(XW'(MAX_SH)))  sh = SH_W'(MAX_SH);
    else                                      sh = sh_full[SH_W-1:0];
  end

  assign kept      = sig >> sh;
  assign half_mask = SIG_W'(1) << (sh - SH_W'(1));
  assign rb        = |(sig & half_mask);
  assign st        = |(sig & (half_mask - SIG_W'(1)));
  assign nx        = rb | st;
  assign rnd_carry = rnd_incr(sgn, rnd_mode, kept[0], rb, st);
  assign exp_field = is_sub ? '0 : hexp[SP_EW-1:0];
  assign mag       = {exp_field, {HP_FW{1'b0}}} + MW'(kept[HP_FW-1:0])
                   + MW'(rnd_carry);
  assign limit     = alt_fmt ? LIM_ALT : LIM_STD;
  assign ovf_hit   = (mag >= limit);
  assign tiny_hit  = is_sub && (tiny_before || (mag < MIN_NORM));

  always_comb begin
    flags_out = '0;
    if (ovf_hit && alt_fmt) begin
      mag_out           = '1;
      flags_out[FLG_NV] = 1'b1;
    end else if (ovf_hit) begin
      mag_out = ovf_to_inf(sgn, rnd_mode) ? LIM_STD[HP_W-2:0]
                                          : LIM_STD[HP_W-2:0] - 1'b1;
      flags_out[FLG_OF] = 1'b1;
      flags_out[FLG_NX] = 1'b1;
    end else begin
      mag_out           = mag[HP_W-2:0];
      flags_out[FLG_NX] = nx;
      flags_out[FLG_UF] = nx && tiny_hit;
    end
  end
endmodule

// File: rtl/spn_special.sv
module spn_special
  import spn_pkg::*;
(
  input  logic             sgn,
  input  op_class_t        cls,
  input  logic [HP_FW-2:0] nan_payload,
  input  logic             alt_fmt,
  input  logic             dnan_en,
  output logic [HP_W-1:0]  sp_bits,
  output logic [FLG_W-1:0] sp_flags
);
  localparam logic [HP_W-2:0] INF_MAG  = {{HP_EW{1'b1}}, {HP_FW{1'b0}}};
  localparam logic [HP_W-1:0] DEF_NAN  = {1'b0, {HP_EW{1'b1}}, 1'b1,
                                          {(HP_FW-1){1'b0}}};

  always_comb begin
    sp_bits  = {sgn, {(HP_W-1){1'b0}}};
    sp_flags = '0;
    case (cls)
      CL_INF: begin
        if (alt_fmt) begin
          sp_bits          = {sgn, {(HP_W-1){1'b1}}};
          sp_flags[FLG_NV] = 1'b1;
        end else begin
          sp_bits = {sgn, INF_MAG};
        end
      end
      CL_QNAN, CL_SNAN: begin
        sp_flags[FLG_NV] = alt_fmt || (cls == CL_SNAN);
        if (alt_fmt)      sp_bits = {sgn, {(HP_W-1){1'b0}}};
        else if (dnan_en) sp_bits = DEF_NAN;
        else              sp_bits = {sgn, {HP_EW{1'b1}}, 1'b1, nan_payload};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sp_to_hp_narrow.sv
module sp_to_hp_narrow
  import spn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SP_W-1:0]   src_bits,
  input  logic              alt_fmt,
  input  logic [2:0]        rnd_mode,
  input  logic              tiny_before,
  input  logic              dnan_en,
  input  logic              flush_in_dn,
  output logic [HP_W-1:0]   dst_bits,
  output logic [FLG_W-1:0]  dst_flags
);
  logic             sgn;
  op_class_t        cls;
  logic [SP_EW-1:0] exp_eff;
  logic [SIG_W-1:0] sig;
  logic [HP_W-2:0]  rp_mag;
  logic [FLG_W-1:0] rp_flags, sp_flags, nx_flags;
  logic [HP_W-1:0]  sp_bits, nx_bits;
  logic             rnd_carry, ovf_hit, tiny_hit;
  logic             is_fin, is_nan;

  spn_classify u_cls (
    .op(src_bits), .flush_in_dn(flush_in_dn),
    .sgn(sgn), .cls(cls), .exp_eff(exp_eff), .sig(sig)
  );

  spn_round_pack u_rnd (
    .sgn(sgn), .exp_eff(exp_eff), .sig(sig), .rnd_mode(rnd_mode),
    .alt_fmt(alt_fmt), .tiny_before(tiny_before),
    .mag_out(rp_mag), .flags_out(rp_flags),
    .rnd_carry(rnd_carry), .ovf_hit(ovf_hit), .tiny_hit(tiny_hit)
  );

  spn_special u_spc (
    .sgn(sgn), .cls(cls), .nan_payload(src_bits[SP_FW-2 -: HP_FW-1]),
    .alt_fmt(alt_fmt), .dnan_en(dnan_en),
    .sp_bits(sp_bits), .sp_flags(sp_flags)
  );

  assign is_fin   = (cls == CL_FINITE);
  assign is_nan   = (cls == CL_QNAN) || (cls == CL_SNAN);
  assign nx_bits  = is_fin ? {sgn, rp_mag} : sp_bits;
  assign nx_flags = is_fin ? rp_flags : sp_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_bits  <= '0;
      dst_flags <= '0;
    end else begin
      dst_bits  <= nx_bits;
      dst_flags <= nx_flags;
    end
  end
endmodule

// File: rtl/spn_checker.sv
module spn_checker
  import spn_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             alt_fmt,
  input logic             dnan_en,
  input logic             is_nan,
  input logic             is_fin,
  input logic             ovf_hit,
  input logic             rnd_carry,
  input logic             tiny_hit,
  input logic [HP_W-1:0]  nx_bits,
  input logic [FLG_W-1:0] nx_flags
);
  assert_alt_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alt_fmt |-> !nx_flags[FLG_OF]);

  assert_overflow_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fin && ovf_hit && !alt_fmt) |-> (nx_flags == 4'b0101));

  assert_underflow_inexact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nx_flags[FLG_UF] |-> (nx_flags[FLG_NX] && tiny_hit));

  assert_default_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nan && dnan_en && !alt_fmt) |-> (nx_bits == 16'h7E00));

  assert_alt_nan_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nan && alt_fmt) |-> (nx_bits[HP_W-2:0] == '0 && nx_flags == 4'b1000));

  assert_no_invalid_finite_std_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fin && !alt_fmt) |-> !nx_flags[FLG_NV]);

  assert_carry_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fin && rnd_carry && !ovf_hit) |-> (nx_bits[HP_W-2:0] != '0));
endmodule

bind sp_to_hp_narrow spn_checker u_spn_checker (
  .clk(clk), .rst_n(rst_n), .alt_fmt(alt_fmt), .dnan_en(dnan_en),
  .is_nan(is_nan), .is_fin(is_fin), .ovf_hit(ovf_hit),
  .rnd_carry(rnd_carry), .tiny_hit(tiny_hit),
  .nx_bits(nx_bits), .nx_flags(nx_flags)
);

// File: tb/test_sp_to_hp_narrow.sv
`timescale 1ns/1ps
module test_sp_to_hp_narrow;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_bits = '0;
  logic        alt_fmt = 1'b0;
  logic [2:0]  rnd_mode = '0;
  logic        tiny_before = 1'b0;
  logic        dnan_en = 1'b0;
  logic        flush_in_dn = 1'b0;
  logic [15:0] dst_bits;
  logic [3:0]  dst_flags;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [19:0] v;
    int          cyc;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  exp_t it;

  always #4 clk = ~clk;

  sp_to_hp_narrow i_sp_to_hp_narrow (
    .clk(clk), .rst_n(rst_n), .src_bits(src_bits), .alt_fmt(alt_fmt),
    .rnd_mode(rnd_mode), .tiny_before(tiny_before), .dnan_en(dnan_en),
    .flush_in_dn(flush_in_dn), .dst_bits(dst_bits), .dst_flags(dst_flags)
  );

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // independent bit-serial model of the conversion
  function automatic logic [19:0] ref_conv(input logic [31:0] a, input logic alt,
      input logic [2:0] rm, input logic tb, input logic dn, input logic fz);
    logic s, rb, st, tiny, nx, inc;
    int e, f, ex, hb, d, q, val;
    logic [2:0] m;
    s = a[31]; e = int'(a[30:23]); f = int'(a[22:0]);
    m = (rm > 3'd4) ? 3'd0 : rm;
    if (e == 255) begin
      if (f == 0) return alt ? {s, 15'h7FFF, 4'b1000} : {s, 15'h7C00, 4'b0000};
      if (alt) return {s, 15'h0000, 4'b1000};
      if (dn) return {16'h7E00, ~a[22], 3'b000};
      return {s, 5'h1F, 1'b1, a[21:13], ~a[22], 3'b000};
    end
    if (e == 0 && (f == 0 || fz)) return {s, 15'h0000, 4'b0000};
    q  = (e == 0) ? f : f + (1 << 23);
    ex = (e == 0) ? 1 : e;
    hb = ex - 112;
    d  = (hb >= 1) ? 13 : 14 - hb;
    rb = 1'b0; st = 1'b0;
    for (int i = 0; i < d; i++) begin
      st = st | rb;
      rb = q[0];
      q  = q >> 1;
    end
    case (m)
      3'd1: inc = 1'b0;
      3'd2: inc = s & (rb | st);
      3'd3: inc = ~s & (rb | st);
      3'd4: inc = rb;
      default: inc = rb & (st | q[0]);
    endcase
    q  = q + int'(inc);
    nx = rb | st;
    val = (hb >= 1) ? hb * 1024 + q - 1024 : q;
    if (alt) begin
      if (val > 32767) return {s, 15'h7FFF, 4'b1000};
    end else if (val > 31743) begin
      if (m == 3'd1 || (m == 3'd2 && !s) || (m == 3'd3 && s))
        return {s, 15'h7BFF, 4'b0101};
      return {s, 15'h7C00, 4'b0101};
    end
    tiny = (hb < 1) && (tb || val < 1024);
    return {s, val[14:0], 2'b00, tiny & nx, nx};
  endfunction

  task automatic drive(input logic [31:0] a, input logic alt, input logic [2:0] rm,
      input logic tb, input logic dn, input logic fz,
      input logic [19:0] expv, input string tag);
    exp_t e;
    @(negedge clk);
    src_bits = a; alt_fmt = alt; rnd_mode = rm;
    tiny_before = tb; dnan_en = dn; flush_in_dn = fz;
    e.v = expv; e.cyc = cyc_cnt; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: result of an item pushed in cycle n is checked one edge later
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].cyc < cyc_cnt) begin
      it = sb_q.pop_front();
      n_chk++;
      if ({dst_bits, dst_flags} !== it.v) begin
        n_fail++;
        $display("FAIL %s: got bits=%h flags=%b expected bits=%h flags=%b",
                 it.tag, dst_bits, dst_flags, it.v[19:4], it.v[3:0]);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    src_bits = 32'h3F80_0000;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({dst_bits, dst_flags} !== 20'h0) begin
      n_fail++;
      $display("FAIL R1 reset: got %h/%b expected 0000/0000", dst_bits, dst_flags);
    end
    rst_n = 1'b1;

    // R2 rounding
    drive(32'h3F80_0000, 0, 0, 0, 0, 0, {16'h3C00, 4'b0000}, "R2 one");
    drive(32'h3F80_1000, 0, 0, 0, 0, 0, {16'h3C00, 4'b0001}, "R2 tie even down");
    drive(32'h3F80_3000, 0, 0, 0, 0, 0, {16'h3C02, 4'b0001}, "R2 tie even up");
    drive(32'h3F80_1000, 0, 4, 0, 0, 0, {16'h3C01, 4'b0001}, "R2 ties away");
    drive(32'h3F80_3000, 0, 1, 0, 0, 0, {16'h3C01, 4'b0001}, "R2 toward zero");
    drive(32'h3F80_3000, 0, 7, 0, 0, 0, {16'h3C02, 4'b0001}, "R2 reserved code");
    drive(32'h3FFF_F000, 0, 0, 0, 0, 0, {16'h4000, 4'b0001}, "R2 carry to exponent");
    drive(32'hBF80_1000, 0, 2, 0, 0, 0, {16'hBC01, 4'b0001}, "R2 down negative");
    drive(32'hBF80_1000, 0, 3, 0, 0, 0, {16'hBC00, 4'b0001}, "R2 up negative");
    // R3 standard overflow
    drive(32'h477F_E000, 0, 0, 0, 0, 0, {16'h7BFF, 4'b0000}, "R3 max finite exact");
    drive(32'h477F_F000, 0, 0, 0, 0, 0, {16'h7C00, 4'b0101}, "R3 round to inf");
    drive(32'h477F_F000, 0, 1, 0, 0, 0, {16'h7BFF, 4'b0001}, "R3 rtz no overflow");
    drive(32'h4800_0000, 0, 1, 0, 0, 0, {16'h7BFF, 4'b0101}, "R3 rtz overflow");
    drive(32'hC800_0000, 0, 2, 0, 0, 0, {16'hFC00, 4'b0101}, "R3 down negative inf");
    drive(32'hC800_0000, 0, 3, 0, 0, 0, {16'hFBFF, 4'b0101}, "R3 up negative max");
    // R4 alternative range
    drive(32'h477F_F000, 1, 0, 0, 0, 0, {16'h7C00, 4'b0001}, "R4 top exponent finite");
    drive(32'h4780_0000, 1, 0, 0, 0, 0, {16'h7C00, 4'b0000}, "R4 exact 65536");
    drive(32'h47FF_E000, 1, 0, 0, 0, 0, {16'h7FFF, 4'b0000}, "R4 max exact");
    drive(32'h4800_0000, 1, 0, 0, 0, 0, {16'h7FFF, 4'b1000}, "R4 too large");
    drive(32'hC800_0000, 1, 1, 0, 0, 0, {16'hFFFF, 4'b1000}, "R4 too large negative");
    // R5 NaN quieting
    drive(32'h7FC0_0000, 0, 0, 0, 0, 0, {16'h7E00, 4'b0000}, "R5 quiet nan");
    drive(32'h7F80_0001, 0, 0, 0, 0, 0, {16'h7E00, 4'b1000}, "R5 snan quieted");
    drive(32'hFFA0_0000, 0, 0, 0, 0, 0, {16'hFF00, 4'b1000}, "R5 snan payload");
    drive(32'hFFC1_2345, 0, 0, 0, 0, 0, {16'hFE09, 4'b0000}, "R5 qnan payload");
    // R6 default NaN
    drive(32'hFFA0_0000, 0, 0, 0, 1, 0, {16'h7E00, 4'b1000}, "R6 default snan");
    drive(32'hFFC1_2345, 0, 0, 0, 1, 0, {16'h7E00, 4'b0000}, "R6 default qnan");
    // R7 alternative specials
    drive(32'hFFC0_0000, 1, 0, 0, 0, 0, {16'h8000, 4'b1000}, "R7 nan to neg zero");
    drive(32'h7F80_0001, 1, 0, 0, 1, 0, {16'h0000, 4'b1000}, "R7 snan to zero");
    drive(32'h7F80_0000, 1, 0, 0, 0, 0, {16'h7FFF, 4'b1000}, "R7 inf to max");
    drive(32'hFF80_0000, 1, 0, 0, 0, 0, {16'hFFFF, 4'b1000}, "R7 neg inf to max");
    // R8 standard infinity
    drive(32'h7F80_0000, 0, 0, 0, 0, 0, {16'h7C00, 4'b0000}, "R8 inf");
    drive(32'hFF80_0000, 0, 3, 0, 0, 0, {16'hFC00, 4'b0000}, "R8 neg inf");
    // R9 subnormals
    drive(32'h3380_0000, 0, 0, 0, 0, 0, {16'h0001, 4'b0000}, "R9 min subnormal");
    drive(32'h3800_0000, 0, 0, 0, 0, 0, {16'h0200, 4'b0000}, "R9 half min normal");
    drive(32'h3300_0000, 0, 0, 0, 0, 0, {16'h0000, 4'b0011}, "R9 tie to zero");
    drive(32'h3300_0000, 0, 4, 0, 0, 0, {16'h0001, 4'b0011}, "R9 tie away");
    drive(32'hB300_0000, 0, 2, 0, 0, 0, {16'h8001, 4'b0011}, "R9 down negative");
    drive(32'hB200_0000, 0, 0, 0, 0, 0, {16'h8000, 4'b0011}, "R9 below smallest");
    // R10 tininess
    drive(32'h387F_FFFF, 0, 0, 1, 0, 0, {16'h0400, 4'b0011}, "R10 tiny before");
    drive(32'h387F_FFFF, 0, 0, 0, 0, 0, {16'h0400, 4'b0001}, "R10 tiny after");
    drive(32'h387F_FFFF, 0, 1, 0, 0, 0, {16'h03FF, 4'b0011}, "R10 stays subnormal");
    // R11 input flush
    drive(32'h0000_0001, 0, 0, 0, 0, 1, {16'h0000, 4'b0000}, "R11 flushed");
    drive(32'h8040_0000, 0, 3, 0, 0, 1, {16'h8000, 4'b0000}, "R11 flushed negative");
    drive(32'h0000_0001, 0, 3, 0, 0, 0, {16'h0001, 4'b0011}, "R11 kept up");
    drive(32'h0000_0001, 0, 0, 0, 0, 0, {16'h0000, 4'b0011}, "R11 kept even");
    // R12 zeros
    drive(32'h8000_0000, 0, 0, 0, 0, 0, {16'h8000, 4'b0000}, "R12 neg zero");
    drive(32'h0000_0000, 1, 2, 0, 0, 0, {16'h0000, 4'b0000}, "R12 pos zero alt");

    // sweep across modes against the model (R2, R9, R10 and the rest)
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a;
      int sel;
      logic alt, tb, dn, fz;
      logic [2:0] rm;
      a = $urandom;
      sel = $urandom_range(0, 15);
      if (sel == 0)      a[30:23] = 8'hFF;
      else if (sel == 1) a[30:23] = 8'h00;
      else               a[30:23] = 8'($urandom_range(95, 146));
      alt = 1'($urandom_range(0, 1));
      tb  = 1'($urandom_range(0, 1));
      dn  = 1'($urandom_range(0, 1));
      fz  = 1'($urandom_range(0, 1));
      rm  = 3'($urandom_range(0, 7));
      drive(a, alt, rm, tb, dn, fz, ref_conv(a, alt, rm, tb, dn, fz), "sweep R2");
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule